// File: doc/BRIEF.md
# DTMF Tone Pair Frequency Decoder

This block turns two squared tone signals, one carrying the low (row) group and one carrying the high (column) group of a dual-tone keypad signal, into a 4-bit key code. For each group it counts reference-clock cycles across a fixed number of tone periods. It compares that count against four acceptance windows, one per nominal frequency of the group. The window limits are constants that elaboration works out from the reference clock rate, so no divider is built.

A group is declared valid only after several back-to-back measurements land in the same window. It loses validity at once on a measurement that fits no window. It also loses validity when its input shows no rising edge for a silence limit. While both groups are valid the early-steering output is high and the key code shows the decoded pair. The code is held after the pair goes away. A suppress input takes the fourth column (keys A to D) out of service.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `early_steer` is cleared to 0 and `key_code` to 4'b0000 at that edge.
- R2: Low-group frequencies are 697, 770, 852 and 941 Hz, rows 0 to 3. A tone within 1.5 % + 2 Hz of one of them is accepted. A tone 3.5 % or more away from every one of them never makes the low group valid.
- R3: High-group frequencies are 1209, 1336, 1477 and 1633 Hz, columns 0 to 3, with the same accept and reject tolerances as R2.
- R4: For rows 0 to 2 and columns 0 to 2, keys 1 to 9 (row-major) give codes 4'b0001 to 4'b1001.
- R5: Row 3 gives 4'b1011 with column 0 (key *), 4'b1010 with column 1 (key 0) and 4'b1100 with column 2 (key #).
- R6: Column 3 gives 4'b1101, 4'b1110 and 4'b1111 for rows 0, 1 and 2 (keys A, B, C), and 4'b0000 for row 3 (key D).
- R7: A group becomes valid only after RUN_NEED (default 4) consecutive measurements, each spanning PER_AVG (default 2) periods, fall in the same window. A tone burst shorter than that never raises `early_steer`.
- R8: A measurement that fits no window clears that group's validity, and `early_steer` falls even while the other group stays valid.
- R9: A group that sees no rising edge for twice the longest accepted period of its lowest tone loses validity. A shorter silence leaves `early_steer` high.
- R10: While `suppress_col4` is high, a 1633 Hz tone never counts as valid. Raising it while a column-3 key is active drops `early_steer` within two clocks. Columns 0 to 2 are unaffected.
- R11: `key_code` changes only in cycles where `early_steer` is high. It keeps the last decoded code after `early_steer` falls and through rejected tones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference time base (CLK_HZ) |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_low | input | 1 | Squared low-group tone, asynchronous |
| tone_high | input | 1 | Squared high-group tone, asynchronous |
| suppress_col4 | input | 1 | High: the 1633 Hz column is never valid |
| early_steer | output | 1 | High while both groups hold a valid tone |
| key_code | output | 4 | Code of the most recent valid pair |

## Verification
A rising edge on a tone input is first sampled by one clock edge. The result can change `early_steer` and `key_code` no earlier than four clock edges after that: two synchroniser stages, the measurement strobe, the classifier run update and the output register. A group needs about nine tone periods to become valid, and a silent group needs its silence limit to drop out. The bench therefore samples each result hundreds of cycles after its last qualifying edge, and well before the next event that could change it. The one short-latency result, the suppress input taking effect, is sampled five cycles after the change, against a two-clock bound.

// File: rtl/dtmf_pair_pkg.sv
// Package: shared constants and elaboration-time helpers for the DTMF
// tone pair decoder. Assumes every frequency is an integer in Hz and that
// the clock rate fits in 32 bits; all results are cycle counts.
package dtmf_pair_pkg;

    localparam int NUM_WIN = 4;

    // Nominal tone of window w in group grp (0 = low/rows, 1 = high/columns).
    function automatic int tone_hz(input int grp, input int w);
        int f;
        if (grp == 0) begin
            case (w)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end else begin
            case (w)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // Shortest accepted count over avg periods: tone 2.5 % fast.
    function automatic int win_lo_cyc(input int clk_hz, input int avg, input int f);
        longint num;
        num = longint'(clk_hz) * longint'(avg) * 64'd1000;
        return int'(num / (longint'(f) * 64'd1025));
    endfunction

    // Longest accepted count over avg periods: tone 2.5 % slow.
    function automatic int win_hi_cyc(input int clk_hz, input int avg, input int f);
        longint num;
        num = longint'(clk_hz) * longint'(avg) * 64'd1000;
        return int'(num / (longint'(f) * 64'd975));
    endfunction

    // Silence limit: twice the longest accepted single period of the group.
    function automatic int silence_cyc(input int clk_hz, input int grp);
        return 2 * win_hi_cyc(clk_hz, 1, tone_hz(grp, 0));
    endfunction

    // Row/column to key code; column 3 wraps row 3 (key D) to zero.
    function automatic logic [3:0] key_of(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] k;
        if (col == 2'd3) begin
            k = 4'(13 + int'(row));
        end else if (row == 2'd3) begin
            case (col)
                2'd0:    k = 4'd11;
                2'd1:    k = 4'd10;
                default: k = 4'd12;
            endcase
        end else begin
            k = 4'(int'(row) * 3 + int'(col) + 1);
        end
        return k;
    endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
// Module: brings one asynchronous squared tone into the clock domain and
// flags its rising edges. Assumes the tone is far slower than the clock;
// latency is STAGES edges to the rise flag.
module dtmf_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tone_in,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh;

    // Shift the tone through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[SH_W-2:0], tone_in};
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/dtmf_period_meter.sv
// Module: counts clock cycles spanning PER_AVG tone periods between rising
// edges and strobes the count out. Stops measuring and strobes a silence
// flag after TMO_CYC cycles without a rise; the next rise re-arms it.
// Assumes MEAS_W holds PER_AVG * TMO_CYC.
module dtmf_period_meter #(
    parameter int PER_AVG = 2,
    parameter int TMO_CYC = 600,
    parameter int MEAS_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    output logic              meas_stb,
    output logic [MEAS_W-1:0] meas,
    output logic              tmo_stb
);
    localparam int PER_W = $clog2(PER_AVG) + 1;
    localparam int GAP_W = $clog2(TMO_CYC + 1) + 1;
    localparam logic [PER_W-1:0] LAST_PER = PER_W'(PER_AVG - 1);
    localparam logic [GAP_W-1:0] GAP_MAX  = GAP_W'(TMO_CYC);
    localparam logic [GAP_W-1:0] GAP_TRIP = GAP_W'(TMO_CYC - 1);

    logic              armed;
    logic [MEAS_W-1:0] cnt;
    logic [PER_W-1:0]  nper;
    logic [GAP_W-1:0]  gap;

    // Span counter: restarts on the edge that closes a measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            cnt      <= '0;
            nper     <= '0;
            meas     <= '0;
            meas_stb <= 1'b0;
        end else begin
            meas_stb <= 1'b0;
            if (rise) begin
                if (!armed) begin
                    armed <= 1'b1;
                    cnt   <= '0;
                    nper  <= '0;
                end else if (nper == LAST_PER) begin
                    meas     <= cnt + 1'b1;
                    meas_stb <= 1'b1;
                    cnt      <= '0;
                    nper     <= '0;
                end else begin
                    nper <= nper + 1'b1;
                    cnt  <= cnt + 1'b1;
                end
            end else if (armed) begin
                if (gap == GAP_TRIP) begin
                    armed <= 1'b0;
                end
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Silence watch: cycles since the last rise, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '0;
            tmo_stb <= 1'b0;
        end else begin
            tmo_stb <= 1'b0;
            if (rise) begin
                gap <= '0;
            end else begin
                if (gap == GAP_TRIP && armed) begin
                    tmo_stb <= 1'b1;
                end
                if (gap != GAP_MAX) begin
                    gap <= gap + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dtmf_tone_classifier.sv
// Module: matches each measurement against the four windows of its group.
// It declares the group valid after RUN_NEED consecutive hits in one window
// and clears on a miss or a silence strobe. Windows set in block_mask
// count as misses. Assumes the windows do not overlap.
module dtmf_tone_classifier
    import dtmf_pair_pkg::*;
#(
    parameter int GRP      = 0,
    parameter int CLK_HZ   = 3579545,
    parameter int PER_AVG  = 2,
    parameter int RUN_NEED = 4,
    parameter int MEAS_W   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_stb,
    input  logic [MEAS_W-1:0] meas,
    input  logic              tmo_stb,
    input  logic [3:0]        block_mask,
    output logic              hit,
    output logic              valid,
    output logic [1:0]        idx
);
    localparam int RUN_W = $clog2(RUN_NEED + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(RUN_NEED);

    logic [NUM_WIN-1:0] in_win;
    logic [NUM_WIN-1:0] ok_win;
    logic [1:0]         hit_idx;
    logic [RUN_W-1:0]   run;

    // One pair of comparators per nominal tone, limits fixed at elaboration.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam int LO = win_lo_cyc(CLK_HZ, PER_AVG, tone_hz(GRP, w));
        localparam int HI = win_hi_cyc(CLK_HZ, PER_AVG, tone_hz(GRP, w));
        assign in_win[w] = (meas >= MEAS_W'(LO)) && (meas <= MEAS_W'(HI));
    end

    assign ok_win = in_win & ~block_mask;
    assign hit    = |ok_win;

    // Encode the matching window; at most one can match.
    always_comb begin
        hit_idx = 2'd0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (ok_win[w]) hit_idx = 2'(w);
        end
    end

    // Run length of consecutive hits in the same window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
            idx <= 2'd0;
        end else if (meas_stb) begin
            if (!hit) begin
                run <= '0;
            end else if (run != '0 && hit_idx == idx) begin
                if (run != RUN_FULL) run <= run + 1'b1;
            end else begin
                idx <= hit_idx;
                run <= RUN_W'(1);
            end
        end else if (tmo_stb) begin
            run <= '0;
        end
    end

    assign valid = (run == RUN_FULL);

endmodule

// File: rtl/dtmf_pair_decoder.sv
// Module: top of the DTMF tone pair decoder. One synchroniser, period
// meter and classifier per group; the early-steer flag and key code are
// registered together. Assumes squared tone inputs and a clock of CLK_HZ.
module dtmf_pair_decoder
    import dtmf_pair_pkg::*;
#(
    parameter int CLK_HZ      = 3579545,
    parameter int PER_AVG     = 2,
    parameter int RUN_NEED    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_low,
    input  logic       tone_high,
    input  logic       suppress_col4,
    output logic       early_steer,
    output logic [3:0] key_code
);
    localparam int TMO_MAX = silence_cyc(CLK_HZ, 0);
    localparam int MEAS_W  = $clog2(PER_AVG * TMO_MAX + 2) + 1;

    logic [1:0]             tone_pair;
    logic [1:0]             grp_rise;
    logic [1:0]             grp_stb;
    logic [1:0]             grp_tmo;
    logic [1:0]             grp_hit;
    logic [1:0]             grp_valid;
    logic [1:0][1:0]        grp_idx;
    logic [1:0][3:0]        grp_block;
    logic [1:0][MEAS_W-1:0] grp_meas;
    logic                   col_ok;
    logic                   pair_ok;
    logic                   est_q;
    logic [3:0]             code_q;

    assign tone_pair    = {tone_high, tone_low};
    assign grp_block[0] = 4'b0000;
    assign grp_block[1] = {suppress_col4, 3'b000};

    // Identical measurement path per group; only the windows differ.
    for (genvar g = 0; g < 2; g++) begin : g_grp
        localparam int TMO = silence_cyc(CLK_HZ, g);

        dtmf_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .tone_in (tone_pair[g]),
            .rise    (grp_rise[g])
        );

        dtmf_period_meter #(
            .PER_AVG (PER_AVG),
            .TMO_CYC (TMO),
            .MEAS_W  (MEAS_W)
        ) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (grp_rise[g]),
            .meas_stb (grp_stb[g]),
            .meas     (grp_meas[g]),
            .tmo_stb  (grp_tmo[g])
        );

        dtmf_tone_classifier #(
            .GRP      (g),
            .CLK_HZ   (CLK_HZ),
            .PER_AVG  (PER_AVG),
            .RUN_NEED (RUN_NEED),
            .MEAS_W   (MEAS_W)
        ) u_cls (
            .clk        (clk),
            .rst_n      (rst_n),
            .meas_stb   (grp_stb[g]),
            .meas       (grp_meas[g]),
            .tmo_stb    (grp_tmo[g]),
            .block_mask (grp_block[g]),
            .hit        (grp_hit[g]),
            .valid      (grp_valid[g]),
            .idx        (grp_idx[g])
        );
    end

    // A column already held valid is dropped at once when suppressed.
    assign col_ok  = grp_valid[1] & ~(suppress_col4 && grp_idx[1] == 2'd3);
    assign pair_ok = grp_valid[0] & col_ok;

    // Register the steer flag and capture the code of a valid pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_q  <= 1'b0;
            code_q <= 4'b0000;
        end else begin
            est_q <= pair_ok;
            if (pair_ok) code_q <= key_of(grp_idx[0], grp_idx[1]);
        end
    end

    assign early_steer = est_q;
    assign key_code    = code_q;

endmodule

// File: rtl/dtmf_pair_decoder_chk.sv
// Checker: temporal properties of the DTMF tone pair decoder, bound to
// the top module. Observes per-group strobes and validity plus the ports.
module dtmf_pair_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       suppress_col4,
    input logic       early_steer,
    input logic [3:0] key_code,
    input logic [1:0] grp_stb,
    input logic [1:0] grp_tmo,
    input logic [1:0] grp_hit,
    input logic [1:0] grp_valid
);
    for (genvar g = 0; g < 2; g++) begin : g_chk
        // R8: a measurement outside every window clears the group next cycle.
        a_r8_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
            grp_stb[g] && !grp_hit[g] |=> !grp_valid[g]);

        // R8: the same miss brings early_steer low one cycle later.
        a_r8_miss_drops_steer: assert property (@(posedge clk) disable iff (!rst_n)
            grp_stb[g] && !grp_hit[g] |=> ##1 !early_steer);

        // R9: the silence strobe clears the group.
        a_r9_silence_clears: assert property (@(posedge clk) disable iff (!rst_n)
            grp_tmo[g] |=> !grp_valid[g]);
    end

    // R11: the code moves only together with a high steer flag.
    a_r11_code_moves_with_steer: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code) |-> early_steer);

    // R10: with the fourth column suppressed no key D code is steered.
    a_r10_no_col4_when_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        early_steer && $past(suppress_col4) |-> key_code != 4'b0000);

endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .suppress_col4 (suppress_col4),
    .early_steer   (early_steer),
    .key_code      (key_code),
    .grp_stb       (grp_stb),
    .grp_tmo       (grp_tmo),
    .grp_hit       (grp_hit),
    .grp_valid     (grp_valid)
);

// File: tb/dtmf_pair_decoder_bench.sv
// Bench: the simulation clock stands in for a 200 kHz time base so that
// tones last a few thousand cycles. The table walk covers all keys and the
// tolerance edges; directed tests cover reset, dropout, miss and suppress.
module dtmf_pair_decoder_bench;
    localparam int CLK_HZ = 200000;
    localparam int NVEC   = 21;

    // {req[33:30], low Hz[29:18], high Hz[17:6], suppress[5], est[4], code[3:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {4'd4, 12'd697, 12'd1209, 1'b0, 1'b1, 4'd1},   // R4 key 1
        {4'd4, 12'd697, 12'd1336, 1'b0, 1'b1, 4'd2},   // R4
        {4'd4, 12'd697, 12'd1477, 1'b0, 1'b1, 4'd3},
        {4'd4, 12'd770, 12'd1209, 1'b0, 1'b1, 4'd4},
        {4'd4, 12'd770, 12'd1336, 1'b0, 1'b1, 4'd5},
        {4'd4, 12'd770, 12'd1477, 1'b0, 1'b1, 4'd6},
        {4'd4, 12'd852, 12'd1209, 1'b0, 1'b1, 4'd7},
        {4'd4, 12'd852, 12'd1336, 1'b0, 1'b1, 4'd8},
        {4'd4, 12'd852, 12'd1477, 1'b0, 1'b1, 4'd9},
        {4'd5, 12'd941, 12'd1336, 1'b0, 1'b1, 4'd10},  // R5 key 0
        {4'd5, 12'd941, 12'd1209, 1'b0, 1'b1, 4'd11},  // R5 key *
        {4'd5, 12'd941, 12'd1477, 1'b0, 1'b1, 4'd12},  // R5 key #
        {4'd6, 12'd697, 12'd1633, 1'b0, 1'b1, 4'd13},  // R6 key A
        {4'd6, 12'd770, 12'd1633, 1'b0, 1'b1, 4'd14},
        {4'd6, 12'd852, 12'd1633, 1'b0, 1'b1, 4'd15},
        {4'd6, 12'd941, 12'd1633, 1'b0, 1'b1, 4'd0},   // R6 key D
        {4'd10, 12'd697, 12'd1633, 1'b1, 1'b0, 4'd0},  // R10 suppressed A
        {4'd10, 12'd941, 12'd1209, 1'b1, 1'b1, 4'd11}, // R10 column 0 still works
        {4'd2, 12'd685, 12'd1356, 1'b0, 1'b1, 4'd2},   // R2 accept edge
        {4'd2, 12'd722, 12'd1336, 1'b0, 1'b0, 4'd0},   // R2 reject 3.5 % off
        {4'd3, 12'd697, 12'd1166, 1'b0, 1'b0, 4'd0}    // R3 reject 3.5 % off
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_low = 1'b0;
    logic       tone_high = 1'b0;
    logic       suppress_col4 = 1'b0;
    logic       early_steer;
    logic [3:0] key_code;

    int  lo_half = 0;
    int  hi_half = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [3:0] last_code = 4'd0;

    always #5 clk = ~clk;

    dtmf_pair_decoder #(.CLK_HZ(CLK_HZ)) u_dtmf_pair_decoder (
        .clk           (clk),
        .rst_n         (rst_n),
        .tone_low      (tone_low),
        .tone_high     (tone_high),
        .suppress_col4 (suppress_col4),
        .early_steer   (early_steer),
        .key_code      (key_code)
    );

    function automatic int half_of(input int f);
        return (CLK_HZ + f) / (2 * f);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic silence();
        lo_half = 0;
        hi_half = 0;
        wait_cyc(1000);
    endtask

    // Squared tone sources, toggled on falling clock edges.
    initial begin
        forever begin
            if (lo_half == 0) begin
                tone_low = 1'b0;
                @(negedge clk);
            end else begin
                repeat (lo_half) @(negedge clk);
                tone_low = ~tone_low;
            end
        end
    end

    initial begin
        forever begin
            if (hi_half == 0) begin
                tone_high = 1'b0;
                @(negedge clk);
            end else begin
                repeat (hi_half) @(negedge clk);
                tone_high = ~tone_high;
            end
        end
    end

    // Watchdog: an expired run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        check(early_steer == 1'b0, "R1", int'(early_steer), 0);
        check(key_code == 4'd0, "R1", int'(key_code), 0);
        rst_n = 1'b1;
        wait_cyc(4);

        for (int i = 0; i < NVEC; i++) begin
            logic [33:0] v;
            string       rq;
            v  = VEC[i];
            rq = $sformatf("R%0d", int'(v[33:30]));
            suppress_col4 = v[5];
            lo_half = half_of(int'(v[29:18]));
            hi_half = half_of(int'(v[17:6]));
            wait_cyc(1400);
            // R7: too few measurements so far, nothing steered yet.
            check(early_steer == 1'b0, "R7", int'(early_steer), 0);
            check(key_code == last_code, "R11", int'(key_code), int'(last_code));
            wait_cyc(1800);
            check(early_steer == v[4], rq, int'(early_steer), int'(v[4]));
            if (v[4]) begin
                check(key_code == v[3:0], rq, int'(key_code), int'(v[3:0]));
                last_code = v[3:0];
            end else begin
                check(key_code == last_code, rq, int'(key_code), int'(last_code));
            end
            silence();
            check(early_steer == 1'b0, "R9", int'(early_steer), 0);
        end
        suppress_col4 = 1'b0;

        // R9: short silence on the column keeps the pair; long silence drops it.
        lo_half = half_of(770);
        hi_half = half_of(1336);
        wait_cyc(3200);
        check(early_steer == 1'b1, "R9", int'(early_steer), 1);
        hi_half = 0;
        wait_cyc(150);
        check(early_steer == 1'b1, "R9", int'(early_steer), 1);
        wait_cyc(600);
        check(early_steer == 1'b0, "R9", int'(early_steer), 0);
        check(key_code == 4'd5, "R11", int'(key_code), 5);
        silence();

        // R8: the row moves off every window; the pair drops, the code stays.
        lo_half = half_of(697);
        hi_half = half_of(1209);
        wait_cyc(3200);
        check(early_steer == 1'b1, "R8", int'(early_steer), 1);
        lo_half = half_of(735);
        wait_cyc(900);
        check(early_steer == 1'b0, "R8", int'(early_steer), 0);
        check(key_code == 4'd1, "R11", int'(key_code), 1);
        silence();

        // R10: suppressing the fourth column while key D is steered.
        lo_half = half_of(941);
        hi_half = half_of(1633);
        wait_cyc(3200);
        check(early_steer == 1'b1, "R6", int'(early_steer), 1);
        check(key_code == 4'd0, "R6", int'(key_code), 0);
        suppress_col4 = 1'b1;
        wait_cyc(5);
        check(early_steer == 1'b0, "R10", int'(early_steer), 0);
        wait_cyc(1000);
        check(early_steer == 1'b0, "R10", int'(early_steer), 0);
        silence();
        suppress_col4 = 1'b0;

        // R1: reset during an active key clears both outputs.
        lo_half = half_of(852);
        hi_half = half_of(1477);
        wait_cyc(3200);
        check(key_code == 4'd9, "R4", int'(key_code), 9);
        rst_n = 1'b0;
        wait_cyc(3);
        check(early_steer == 1'b0, "R1", int'(early_steer), 0);
        check(key_code == 4'd0, "R1", int'(key_code), 0);
        rst_n = 1'b1;
        silence();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule